// File: doc/BRIEF.md
# Marked Address Indexer and Program Counter

This block forms effective addresses by adding an index to an 18-bit base address, and it holds the program counter. Bit 17 of every address is a mark flag that takes no part in arithmetic: the low 17 bits are the word address and wrap modulo 2^17. The index input is read in one of four ways, chosen by a 2-bit kind select. It can be a 5-bit, 6-bit or 18-bit one's-complement signed value, or an 18-bit unsigned value.

The sum appears combinationally on `idx_result`. On a clock edge the program counter can take that sum (load) or step itself forward by one (increment). A load wins over an increment in the same cycle. Signed subtraction is done with the carry-in forced set, so adding a number to its own complement yields zero rather than all ones.

Top module: `addr_indexer_pc`

## Requirements
- R1: `idx_result[17]` always equals `base_addr[17]`, whatever the index and kind.
- R2: For a positive signed index, the low 17 bits of `idx_result` are the base's low 17 bits plus the magnitude, modulo 2^17.
- R3: For a negative signed index, the magnitude is subtracted modulo 2^17 with the carry forced set: base octal 000004 with 18-bit index octal 777773 gives 0, not octal 377777.
- R4: A signed zero of either sign (all zeros or all ones in the selected width) leaves the address unchanged.
- R5: Kind 0 reads `index_val[4:0]` as one's complement with bit 4 the sign: base octal 4000 with +6 gives octal 4006, and with code 5'b11011 (-4) gives octal 3774.
- R6: Kind 1 reads `index_val[5:0]` as one's complement with bit 5 the sign.
- R7: Kind 3 adds `index_val` unsigned to the low 17 bits modulo 2^17. The carry and `index_val[17]` never reach bit 17.
- R8: Kind 2 reads all 18 bits as one's complement with bit 17 the sign. In kinds 0 and 1, the index bits above the selected width have no effect.
- R9: An increment adds one to the low 17 bits of `pc_addr`, wrapping octal 377777 to 0, and leaves bit 17 unchanged.
- R10: When `load_en` is high, `pc_addr` takes `idx_result` on the next edge, even if `inc_en` is also high.
- R11: A synchronous `rst` clears `pc_addr` to 0. With neither `load_en` nor `inc_en` high, `pc_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | 18 | Base address; bit 17 is the mark |
| index_val | input | 18 | Index operand |
| index_kind | input | 2 | 0: 5-bit signed, 1: 6-bit signed, 2: 18-bit signed, 3: 18-bit unsigned |
| load_en | input | 1 | Load the program counter from the indexed sum |
| inc_en | input | 1 | Increment the program counter |
| idx_result | output | 18 | Combinational indexed address |
| pc_addr | output | 18 | Registered program counter |

## Verification
The hardest case to reach is an increment that wraps while the mark bit is set. The counter can only get there through a load from the adder. The stimulus therefore uses a zero index to load octal 777777 and octal 377776 through the adder, and then issues increments across the wrap. The other awkward cases are the negative zero and the complement-sum pattern that exercises the forced carry. These are driven directly, and the upper index bits are filled with garbage in the narrow kinds.

// File: rtl/addr_idx_pkg.sv
package addr_idx_pkg;
    typedef enum logic [1:0] {
        KIND_S5  = 2'd0,
        KIND_S6  = 2'd1,
        KIND_S18 = 2'd2,
        KIND_U18 = 2'd3
    } index_kind_e;
endpackage

// File: rtl/idx_delta_norm.sv
module idx_delta_norm
    import addr_idx_pkg::*;
#(
    parameter int IDX_W    = 18,
    parameter int NARROW_W = 5,
    parameter int MID_W    = 6,
    parameter int LOW_W    = 17
) (
    input  logic [IDX_W-1:0] index_val,
    input  index_kind_e      kind,
    output logic             neg,
    output logic [LOW_W-1:0] mag
);
    localparam int NMAG_W = NARROW_W - 1;
    localparam int MMAG_W = MID_W - 1;
    localparam int WMAG_W = IDX_W - 1;

    logic [NMAG_W-1:0] n_mag;
    logic [MMAG_W-1:0] m_mag;
    logic [WMAG_W-1:0] w_mag;

    always_comb begin
        // one's complement magnitude per width
        n_mag = index_val[NARROW_W-1] ? ~index_val[NMAG_W-1:0] : index_val[NMAG_W-1:0];
        m_mag = index_val[MID_W-1]    ? ~index_val[MMAG_W-1:0] : index_val[MMAG_W-1:0];
        w_mag = index_val[IDX_W-1]    ? ~index_val[WMAG_W-1:0] : index_val[WMAG_W-1:0];
        neg = 1'b0;
        mag = '0;
        unique case (kind)
            KIND_S5: begin
                neg = index_val[NARROW_W-1];
                mag = LOW_W'(n_mag);
            end
            KIND_S6: begin
                neg = index_val[MID_W-1];
                mag = LOW_W'(m_mag);
            end
            KIND_S18: begin
                neg = index_val[IDX_W-1];
                mag = LOW_W'(w_mag);
            end
            default: begin
                neg = 1'b0;
                mag = index_val[LOW_W-1:0];
            end
        endcase
    end
endmodule

// File: rtl/idx_adder.sv
module idx_adder #(
    parameter int ADDR_W = 18,
    localparam int LOW_W = ADDR_W - 1
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              neg,
    input  logic [LOW_W-1:0]  mag,
    output logic [ADDR_W-1:0] sum_addr
);
    logic [LOW_W-1:0] operand;
    logic             carry_in;
    logic [LOW_W-1:0] low_sum;

    always_comb begin
        // subtraction as add of complement with the carry forced set
        operand  = neg ? ~mag : mag;
        carry_in = neg;
        low_sum  = base_addr[LOW_W-1:0] + operand + LOW_W'(carry_in);
        sum_addr = {base_addr[ADDR_W-1], low_sum};
    end

    always_comb begin
        a_r4_zero_keeps: assert (mag != '0 || sum_addr == base_addr)
            else $error("R4: zero index changed address");
    end
endmodule

// File: rtl/pc_reg.sv
module pc_reg #(
    parameter int ADDR_W = 18,
    localparam int LOW_W = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic              inc_en,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] pc_out
);
    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } pc_state_t;

    pc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.pc = load_val;
        end else if (inc_en) begin
            st_d.pc[LOW_W-1:0] = st_q.pc[LOW_W-1:0] + LOW_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pc_out = st_q.pc;

    a_r11_reset_clears: assert property (@(posedge clk) rst |=> pc_out == '0)
        else $error("R11: reset did not clear");
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !inc_en) |=> $stable(pc_out))
        else $error("R11: counter moved while idle");
    a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
        load_en |=> pc_out == $past(load_val))
        else $error("R10: load not taken");
    a_r9_inc_mark: assert property (@(posedge clk) disable iff (rst)
        (inc_en && !load_en) |=> pc_out[ADDR_W-1] == $past(pc_out[ADDR_W-1]))
        else $error("R9: increment altered mark");
    a_r9_inc_step: assert property (@(posedge clk) disable iff (rst)
        (inc_en && !load_en) |=> pc_out[LOW_W-1:0] == LOW_W'($past(pc_out[LOW_W-1:0]) + LOW_W'(1)))
        else $error("R9: increment wrong");
endmodule

// File: rtl/addr_indexer_pc.sv
module addr_indexer_pc
    import addr_idx_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int NARROW_W = 5,
    parameter int MID_W    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] index_val,
    input  logic [1:0]        index_kind,
    input  logic              load_en,
    input  logic              inc_en,
    output logic [ADDR_W-1:0] idx_result,
    output logic [ADDR_W-1:0] pc_addr
);
    localparam int LOW_W = ADDR_W - 1;

    logic             d_neg;
    logic [LOW_W-1:0] d_mag;

    idx_delta_norm #(
        .IDX_W(ADDR_W), .NARROW_W(NARROW_W), .MID_W(MID_W), .LOW_W(LOW_W)
    ) u_norm (
        .index_val(index_val),
        .kind     (index_kind_e'(index_kind)),
        .neg      (d_neg),
        .mag      (d_mag)
    );

    idx_adder #(.ADDR_W(ADDR_W)) u_add (
        .base_addr(base_addr),
        .neg      (d_neg),
        .mag      (d_mag),
        .sum_addr (idx_result)
    );

    pc_reg #(.ADDR_W(ADDR_W)) u_pc (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .inc_en  (inc_en),
        .load_val(idx_result),
        .pc_out  (pc_addr)
    );

    always_comb begin
        a_r1_mark_pass: assert (idx_result[ADDR_W-1] == base_addr[ADDR_W-1])
            else $error("R1: mark bit not carried");
    end
    a_r7_unsigned_mark: assert property (@(posedge clk) disable iff (rst)
        (index_kind == 2'd3) |-> idx_result[ADDR_W-1] == base_addr[ADDR_W-1])
        else $error("R7: unsigned sum reached mark");
endmodule

// File: tb/sim_addr_indexer_pc.sv
module sim_addr_indexer_pc;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [17:0] base_addr = '0;
    logic [17:0] index_val = '0;
    logic [1:0]  index_kind = '0;
    logic        load_en = 1'b0;
    logic        inc_en = 1'b0;
    logic [17:0] idx_result;
    logic [17:0] pc_addr;

    int n_tests = 0;
    int n_fail = 0;
    logic [17:0] model_pc = '0;

    typedef struct {
        string       tag;
        logic [17:0] exp_idx;
        logic [17:0] exp_pc;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    addr_indexer_pc u0 (
        .clk(clk), .rst(rst), .base_addr(base_addr), .index_val(index_val),
        .index_kind(index_kind), .load_en(load_en), .inc_en(inc_en),
        .idx_result(idx_result), .pc_addr(pc_addr)
    );

    function automatic logic [17:0] ref_idx(input logic [17:0] b, input logic [17:0] ix,
                                            input logic [1:0] k);
        int lo, d, r;
        lo = int'(b[16:0]);
        case (k)
            2'd0: d = ix[4]  ? -(15 - int'(ix[3:0]))      : int'(ix[3:0]);
            2'd1: d = ix[5]  ? -(31 - int'(ix[4:0]))      : int'(ix[4:0]);
            2'd2: d = ix[17] ? -(131071 - int'(ix[16:0])) : int'(ix[16:0]);
            default: d = int'(ix);
        endcase
        r = ((lo + d) % 131072 + 131072) % 131072;
        return {b[17], 17'(r)};
    endfunction

    task automatic step(input string tag, input logic [17:0] b, input logic [17:0] ix,
                        input logic [1:0] k, input logic ld, input logic inc);
        item_t it;
        @(negedge clk);
        base_addr = b; index_val = ix; index_kind = k; load_en = ld; inc_en = inc;
        it.tag = tag;
        it.exp_idx = ref_idx(b, ix, k);
        if (ld)       model_pc = it.exp_idx;
        else if (inc) model_pc = {model_pc[17], 17'(model_pc[16:0] + 17'd1)};
        it.exp_pc = model_pc;
        sb.push_back(it);
    endtask

    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_tests++;
            if (idx_result !== it.exp_idx) begin
                n_fail++;
                $display("FAIL %s idx_result actual %o expected %o", it.tag, idx_result, it.exp_idx);
            end
            n_tests++;
            if (pc_addr !== it.exp_pc) begin
                n_fail++;
                $display("FAIL %s pc_addr actual %o expected %o", it.tag, pc_addr, it.exp_pc);
            end
        end
    end

    task automatic check_pc(input string tag, input logic [17:0] exp);
        n_tests++;
        if (pc_addr !== exp) begin
            n_fail++;
            $display("FAIL %s pc_addr actual %o expected %o", tag, pc_addr, exp);
        end
    endtask

    initial begin
        #(20 * 5000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_pc("R11 reset", 18'o0);
        // R5 narrow signed examples
        step("R5 plus6",  18'o004000, 18'o000006, 2'd0, 1'b0, 1'b0);
        step("R5 minus4", 18'o004000, 18'b11011, 2'd0, 1'b0, 1'b0);
        // R3 forced carry, loaded into counter
        step("R3 cplsum", 18'o000004, 18'o777773, 2'd2, 1'b1, 1'b0);
        // R4 zeros of both signs
        step("R4 pz5",  18'o523456, 18'o000000, 2'd0, 1'b0, 1'b0);
        step("R4 nz5",  18'o523456, 18'o000037, 2'd0, 1'b0, 1'b0);
        step("R4 nz18", 18'o523456, 18'o777777, 2'd2, 1'b0, 1'b0);
        // R1 and R2 mark pass with wrap
        step("R1 markneg", 18'o400010, ~18'o000020, 2'd2, 1'b0, 1'b0);
        step("R2 pos18",   18'o377770, 18'o000020, 2'd2, 1'b0, 1'b0);
        // R6 mid-width
        step("R6 minus3", 18'o000100, 18'b111100, 2'd1, 1'b0, 1'b0);
        step("R6 plus31", 18'o000100, 18'b011111, 2'd1, 1'b0, 1'b0);
        // R7 unsigned
        step("R7 u wrap", 18'o400001, 18'o777777, 2'd3, 1'b0, 1'b0);
        step("R7 u hi",   18'o000005, 18'o400003, 2'd3, 1'b0, 1'b0);
        // R8 upper bits ignored in narrow kinds
        step("R8 s5junk", 18'o004000, 18'o777706, 2'd0, 1'b0, 1'b0);
        step("R8 s6junk", 18'o004000, 18'o777774, 2'd1, 1'b0, 1'b0);
        // R9 wrap with and without mark
        step("R9 ld",    18'o377776, 18'o0, 2'd0, 1'b1, 1'b0);
        step("R9 inc1",  18'o0, 18'o0, 2'd0, 1'b0, 1'b1);
        step("R9 inc2",  18'o0, 18'o0, 2'd0, 1'b0, 1'b1);
        step("R9 ldm",   18'o777777, 18'o0, 2'd0, 1'b1, 1'b0);
        step("R9 incm",  18'o0, 18'o0, 2'd0, 1'b0, 1'b1);
        // R10 load beats increment
        step("R10 both", 18'o012345, 18'o000003, 2'd0, 1'b1, 1'b1);
        // R11 hold
        step("R11 hold", 18'o777000, 18'o000001, 2'd3, 1'b0, 1'b0);
        step("R11 hold2", 18'o111111, 18'o000002, 2'd2, 1'b0, 1'b0);
        @(negedge clk);
        load_en = 1'b0; inc_en = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; inc_en = 1'b0;
        model_pc = '0;
        check_pc("R11 midreset", 18'o0);
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule